// File: doc/BRIEF.md
# Instruction-Count Preemption Timer

This block measures progress through the schedule in retired instructions rather than clock cycles. A static table, loaded while the block is disabled, lists the instruction counts at which a task switch or a data transfer must happen in each scheduling round. The CPU sends one retire strobe per executed instruction. When the running count reaches the value in the current table entry, the block raises a one-cycle interrupt, presents that entry's event index and moves to the next entry. Because the count does not depend on cache timing, every preemption lands at the same program point in every round.

A round begins at a global-time synchronization pulse. That pulse clears the count and returns the table pointer to the first entry. After the entry that closes the round, the block stays idle and ignores retire strobes until the next pulse. This planned window of inactivity absorbs drift between the CPU clock and global time. The window's length is fixed offline by choosing the last entry's count against the allowed skew. If a pulse arrives while the round is still running, the schedule has overrun: a sticky error bit is set and the block resynchronizes anyway.

Top module: `instr_preempt_timer`

## Requirements
- R1: The count advances by one for each clock cycle in which `retire` is high, `en` is high and the block is not idle. Cycles without `retire` do not advance it.
- R2: `irq` is high for exactly the one cycle after the retire that brings the count equal to the current entry's count. In that same cycle, `event_idx` shows that entry's event value, and the pointer moves to the next entry. `event_idx` then holds its value until the next hit.
- R3: A hit on an entry written with its end flag set, or on the last table slot (index N_ENTRIES-1), raises `idle` in the same cycle as that `irq`.
- R4: While `idle` is high, retire strobes produce no `irq` and do not change the count.
- R5: A `sync` pulse while `en` is high clears the count, returns the pointer to entry 0 and drops `idle` on the next cycle.
- R6: A `sync` pulse while `en` is high and `idle` is low sets `overrun`. Only reset clears it.
- R7: `wr_en` writes the entry at `wr_addr` (count `wr_count`, event `wr_event`, end flag `wr_last`) only while `en` is low. Writes while `en` is high are ignored.
- R8: While `en` is low, `retire` and `sync` have no effect: the count, the pointer and `idle` hold, and `irq` stays low.
- R9: After reset, `idle` is 1 and `irq`, `overrun` and `event_idx` are 0. The first round starts at the first `sync`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Run enable; table writable only when low |
| retire | input | 1 | One pulse per retired instruction |
| sync | input | 1 | Global-time synchronization pulse |
| wr_en | input | 1 | Table write strobe |
| wr_addr | input | 4 | Table entry to write |
| wr_count | input | 32 | Instruction count for the entry |
| wr_event | input | 4 | Event index for the entry |
| wr_last | input | 1 | Entry closes the round |
| irq | output | 1 | One-cycle preemption/trigger pulse |
| event_idx | output | 4 | Event index of the latest hit |
| idle | output | 1 | Inactivity window, waiting for sync |
| overrun | output | 1 | Sticky: sync arrived mid-round |

## Verification
On every cycle, the assertions check these properties: `irq` only follows an enabled retire, idle never produces `irq` and only a sync can leave it, a sync always leaves the block running with `irq` low, `overrun` never falls, and a disabled block holds still. Some behaviours can only be shown by the bench's scenarios. These are that hits land on the exact retire counts in the table with the right event values, that the schedule repeats after each resync, that an early sync restarts from entry 0, that writes made while enabled are dropped, and that the pointer stops at the last slot when no entry carries an end flag.

// File: rtl/instr_preempt_timer.sv
module instr_preempt_timer #(
  parameter int N_ENTRIES = 16,
  parameter int CNT_W     = 32,
  parameter int EV_W      = 4,
  localparam int PTR_W    = $clog2(N_ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             retire,
  input  logic             sync,
  input  logic             wr_en,
  input  logic [PTR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0] wr_count,
  input  logic [EV_W-1:0]  wr_event,
  input  logic             wr_last,
  output logic             irq,
  output logic [EV_W-1:0]  event_idx,
  output logic             idle,
  output logic             overrun
);
  logic [CNT_W-1:0] tab_cnt  [N_ENTRIES];
  logic [EV_W-1:0]  tab_ev   [N_ENTRIES];
  logic             tab_last [N_ENTRIES];

  logic [CNT_W-1:0] cnt;
  logic [PTR_W-1:0] ptr;

  wire [CNT_W-1:0] cnt_nx  = cnt + 1'b1;
  wire             step    = en && retire && !idle && !sync;
  wire             hit     = step && (cnt_nx == tab_cnt[ptr]);
  wire             at_end  = tab_last[ptr] || (ptr == PTR_W'(N_ENTRIES - 1));

  always_ff @(posedge clk) begin
    if (wr_en && !en) begin
      tab_cnt[wr_addr]  <= wr_count;
      tab_ev[wr_addr]   <= wr_event;
      tab_last[wr_addr] <= wr_last;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      ptr       <= '0;
      idle      <= 1'b1;
      irq       <= 1'b0;
      overrun   <= 1'b0;
      event_idx <= '0;
    end else begin
      irq <= hit;
      if (en && sync) begin
        cnt  <= '0;
        ptr  <= '0;
        idle <= 1'b0;
        if (!idle) overrun <= 1'b1;
      end else if (step) begin
        cnt <= cnt_nx;
        if (hit) begin
          event_idx <= tab_ev[ptr];
          if (at_end) idle <= 1'b1;
          else        ptr  <= ptr + 1'b1;
        end
      end
    end
  end

  p_irq_after_retire_r2: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(en && retire));
  p_idle_no_irq_r4: assert property (@(posedge clk) disable iff (!rst_n)
    idle && !(en && sync) |=> !irq && idle);
  p_sync_restarts_r5: assert property (@(posedge clk) disable iff (!rst_n)
    en && sync |=> !idle && !irq);
  p_overrun_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);
  p_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !irq && $stable(idle) && $stable(event_idx));
endmodule

// File: tb/tb_instr_preempt_timer.sv
module tb_instr_preempt_timer;
  logic clk = 0, rst_n = 0, en = 0, retire = 0, sync = 0;
  logic wr_en = 0, wr_last = 0;
  logic [3:0] wr_addr = 0, wr_event = 0;
  logic [31:0] wr_count = 0;
  logic irq, idle, overrun;
  logic [3:0] event_idx;
  int tests = 0, fails = 0;

  always #4 clk = ~clk;

  instr_preempt_timer dut (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic r, input logic s);
    retire = r; sync = s;
    @(negedge clk);
    retire = 0; sync = 0;
  endtask

  task automatic wr(input int a, input int c, input int ev, input logic last);
    wr_en = 1; wr_addr = 4'(a); wr_count = c; wr_event = 4'(ev); wr_last = last;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic retire_expect(input int n, input int ev, input string req);
    for (int i = 0; i < n - 1; i++) begin
      step(1, 0); check({req, " early irq"}, irq, 0);
      step(0, 0); check({req, " gap irq"}, irq, 0);
    end
    step(1, 0);
    check({req, " hit irq"}, irq, 1);
    check({req, " hit event"}, event_idx, ev);
    step(0, 0); check({req, " irq one cycle"}, irq, 0);
  endtask

  task automatic t_reset;
    check("R9 idle", idle, 1); check("R9 irq", irq, 0);
    check("R9 overrun", overrun, 0); check("R9 event", event_idx, 0);
  endtask

  task automatic t_round;
    wr(0, 3, 5, 0); wr(1, 5, 9, 0); wr(2, 8, 2, 1);
    en = 1;
    for (int i = 0; i < 4; i++) begin step(1, 0); check("R4 idle before sync", irq, 0); end
    step(0, 1); check("R5 idle dropped", idle, 0); check("R6 no overrun", overrun, 0);
    retire_expect(3, 5, "R1 R2 entry0");
    retire_expect(2, 9, "R2 entry1");
    check("R3 not idle yet", idle, 0);
    retire_expect(3, 2, "R2 R3 entry2");
    check("R3 idle after end", idle, 1);
  endtask

  task automatic t_idle_resync;
    for (int i = 0; i < 10; i++) begin
      step(1, 0); check("R4 irq in idle", irq, 0); check("R4 idle held", idle, 1);
    end
    step(0, 1); check("R5 resync idle", idle, 0); check("R6 clean resync", overrun, 0);
    retire_expect(3, 5, "R5 round repeats");
  endtask

  task automatic t_early_sync;
    step(1, 0);
    step(0, 1); check("R6 overrun set", overrun, 1); check("R5 early sync idle", idle, 0);
    retire_expect(3, 5, "R5 pointer reset");
    check("R6 overrun sticky", overrun, 1);
  endtask

  task automatic t_disable;
    en = 0;
    for (int i = 0; i < 5; i++) begin step(1, 0); check("R8 disabled irq", irq, 0); end
    step(0, 1); check("R8 sync ignored idle", idle, 0);
    en = 1;
    retire_expect(2, 9, "R8 state held");
  endtask

  task automatic t_write_enabled;
    wr(0, 1, 7, 0);
    step(0, 1);
    retire_expect(3, 5, "R7 write while enabled ignored");
  endtask

  task automatic t_wrap;
    en = 0;
    for (int i = 0; i < 16; i++) wr(i, i + 1, 15 - i, 0);
    en = 1;
    step(0, 1);
    for (int i = 0; i < 16; i++) begin
      step(1, 0);
      check("R2 back-to-back irq", irq, 1);
      check("R2 back-to-back event", event_idx, 15 - i);
    end
    check("R3 last slot idle", idle, 1);
    step(1, 0); check("R4 after last slot", irq, 0);
  endtask

  initial begin
    #(8 * 100000);
    fails++; tests++;
    $display("FAIL watchdog R9 act=timeout exp=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_round;
    t_idle_resync;
    t_early_sync;
    t_disable;
    t_write_enabled;
    t_wrap;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule